// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block finds the ratio between a master clock and the sample-rate word clock of an audio port that runs as a slave. It counts master clock cycles from one rising word-clock edge to the next and maps the count to one of seven supported ratios: 128, 192, 256, 384, 512, 768 and 1152. It outputs a 3-bit code that downstream logic uses to pick its divider and filter settings. Four of these ratios are not powers of two, so the block compares the count against each ratio in turn rather than decoding bit positions.

The word clock reaches the block asynchronously. It is synchronised into the master clock domain before any edge is counted. A ratio is reported only after two periods in a row agree. A period that fits no ratio raises an unsupported flag. A word clock that stops is caught when the counter saturates. When the port is the clock master, the block is bypassed and a ratio code supplied by a register is passed to the outputs instead. The count depends only on the ratio, so the same logic serves every sample rate from under 8 kHz to 192 kHz, provided a suitable master clock is present.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted and in slave mode, `valid_o` is 0, `unsup_o` is 0 and `ratio_o` is 0.
- R2: In slave mode, a word-clock period of exactly 128, 192, 256, 384, 512, 768 or 1152 master clock cycles gives code 0, 1, 2, 3, 4, 5 or 6 on `ratio_o`. A period is measured between consecutive rising edges of the synchronised word clock.
- R3: A period within two cycles of a supported ratio (for example 130 or 1150) is classed as that ratio. A period three cycles away (for example 131) matches no ratio.
- R4: `valid_o` rises only after two consecutive measurements give the same code. The first rising edge after reset only starts the count. A measurement with a different code clears `valid_o` until that new code is seen twice in a row.
- R5: A measurement that matches no ratio sets `unsup_o` to 1 and `valid_o` to 0. The next matching measurement clears `unsup_o`.
- R6: The period counter saturates at 2047. If no rising edge arrives for that long, the block sets `unsup_o` and clears `valid_o`. The first period after the word clock restarts counts as 2047 and is unsupported.
- R7: In master mode (`slave_mode_i` = 0), `ratio_o` equals `reg_ratio_i` in the same cycle. `valid_o` is 1 for codes 0 to 6 and `unsup_o` is 1 for code 7. Returning to slave mode shows the detector's result again.
- R8: `valid_o` and `unsup_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic runs on it |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wclk_i | input | 1 | Word clock, asynchronous to `mclk_i` |
| slave_mode_i | input | 1 | 1: detect the ratio; 0: pass the register ratio through |
| reg_ratio_i | input | 3 | Ratio code used in master mode (0 to 6 valid, 7 unsupported) |
| ratio_o | output | 3 | Ratio code: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1152 |
| valid_o | output | 1 | The ratio code is confirmed |
| unsup_o | output | 1 | The last measurement matched no supported ratio |

## Verification
Assertions check on every cycle that:
- the edge detector never gives two pulses back to back;
- at most one ratio window matches a count;
- a saturated counter stays saturated until an edge arrives;
- `valid_o` rises only after a repeated matching measurement;
- a miss always leaves `unsup_o` set and `valid_o` clear;
- the two flags are never set together.

Only the bench scenarios can show the rest. These cover the mapping of real word-clock periods to codes, including the limits of the tolerance window. They also cover:
- the two-period delay before `valid_o` after reset and after a change of ratio;
- recovery after the word clock stops and restarts;
- the master-mode bypass.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIO = 7;
  localparam int CODE_W    = 3;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_NONE = code_t'(7);

  // Master clock cycles per word-clock period for each code.
  function automatic int ratio_of(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      6:       return 1152;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/mrd_rst_sync.sv
module mrd_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/mrd_edge.sv
module mrd_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R2: one pulse per synchronised rising edge
  a_r2_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mrd_period_cnt.sv
module mrd_period_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             stb_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam logic [CNT_W-1:0] SAT  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] PRE  = SAT - ONE;

  logic [CNT_W-1:0] cnt_q, cnt_d, meas_q, meas_d;
  logic             armed_q, armed_d, stb_q, stb_d;
  logic             cnt_en;

  assign cnt_en = rise_i | (cnt_q != SAT);

  always_comb begin
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    armed_d = armed_q;
    stb_d   = 1'b0;
    if (rise_i) begin
      cnt_d   = ONE;
      armed_d = 1'b1;
      if (armed_q) begin
        stb_d  = 1'b1;
        meas_d = cnt_q;
      end
    end else begin
      cnt_d = cnt_q + ONE;
      if (cnt_q == PRE) begin
        stb_d  = 1'b1;
        meas_d = SAT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      meas_q  <= '0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      meas_q  <= meas_d;
      armed_q <= armed_d;
      stb_q   <= stb_d;
    end
  end

  assign stb_o  = stb_q;
  assign meas_o = meas_q;

  // R6: a saturated counter holds until the next edge
  a_r6_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SAT && !rise_i) |=> (cnt_q == SAT));
endmodule

// File: rtl/mrd_classify.sv
module mrd_classify
  import mrd_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] meas_i,
  output logic             hit_o,
  output code_t            code_o
);
  logic [NUM_RATIO-1:0] match;

  for (genvar g = 0; g < NUM_RATIO; g++) begin : g_win
    localparam int R = ratio_of(g);
    localparam logic [CNT_W-1:0] LO = CNT_W'(R - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(R + TOL);
    assign match[g] = (meas_i >= LO) && (meas_i <= HI);
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = 0; i < NUM_RATIO; i++) begin
      if (match[i]) code_o = code_t'(i);
    end
  end

  assign hit_o = |match;

  // R3: tolerance windows never overlap
  a_r3_one_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/mrd_qualify.sv
module mrd_qualify
  import mrd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stb_i,
  input  logic  hit_i,
  input  code_t code_i,
  output logic  valid_o,
  output logic  unsup_o,
  output code_t code_o
);
  logic  valid_q, valid_d, unsup_q, unsup_d, seen_q, seen_d;
  code_t conf_q, conf_d, last_q, last_d;

  always_comb begin
    valid_d = valid_q;
    unsup_d = unsup_q;
    seen_d  = seen_q;
    conf_d  = conf_q;
    last_d  = last_q;
    if (stb_i) begin
      if (hit_i) begin
        unsup_d = 1'b0;
        seen_d  = 1'b1;
        last_d  = code_i;
        if (seen_q && last_q == code_i) begin
          valid_d = 1'b1;
          conf_d  = code_i;
        end else begin
          valid_d = 1'b0;
        end
      end else begin
        valid_d = 1'b0;
        unsup_d = 1'b1;
        seen_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      unsup_q <= 1'b0;
      seen_q  <= 1'b0;
      conf_q  <= '0;
      last_q  <= '0;
    end else if (stb_i) begin
      valid_q <= valid_d;
      unsup_q <= unsup_d;
      seen_q  <= seen_d;
      conf_q  <= conf_d;
      last_q  <= last_d;
    end
  end

  assign valid_o = valid_q;
  assign unsup_o = unsup_q;
  assign code_o  = conf_q;

  // R4: valid rises only on a second agreeing measurement
  a_r4_two_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> ($past(stb_i) && $past(hit_i) && $past(seen_q)));

  // R5: a miss leaves the block unsupported and not valid
  a_r5_miss_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !hit_i) |=> (unsup_q && !valid_q));

  // R8: flags are exclusive
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && unsup_q));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mclk_i,
  input  logic              arst_ni,
  input  logic              wclk_i,
  input  logic              slave_mode_i,
  input  logic [CODE_W-1:0] reg_ratio_i,
  output logic [CODE_W-1:0] ratio_o,
  output logic              valid_o,
  output logic              unsup_o
);
  logic             rst_n, rise, stb, hit;
  logic [CNT_W-1:0] meas;
  code_t            cls_code, det_code;
  logic             det_valid, det_unsup;

  mrd_rst_sync u_rst (
    .clk_i   (mclk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  mrd_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (mclk_i),
    .rst_ni  (rst_n),
    .async_i (wclk_i),
    .rise_o  (rise)
  );

  mrd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (mclk_i),
    .rst_ni (rst_n),
    .rise_i (rise),
    .stb_o  (stb),
    .meas_o (meas)
  );

  mrd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .clk_i  (mclk_i),
    .rst_ni (rst_n),
    .meas_i (meas),
    .hit_o  (hit),
    .code_o (cls_code)
  );

  mrd_qualify u_qual (
    .clk_i   (mclk_i),
    .rst_ni  (rst_n),
    .stb_i   (stb),
    .hit_i   (hit),
    .code_i  (cls_code),
    .valid_o (det_valid),
    .unsup_o (det_unsup),
    .code_o  (det_code)
  );

  always_comb begin
    if (slave_mode_i) begin
      ratio_o = det_code;
      valid_o = det_valid;
      unsup_o = det_unsup;
    end else begin
      ratio_o = reg_ratio_i;
      valid_o = (reg_ratio_i != CODE_NONE);
      unsup_o = (reg_ratio_i == CODE_NONE);
    end
  end
endmodule

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       wclk;
  logic       slave;
  logic [2:0] reg_ratio;
  logic [2:0] ratio;
  logic       valid, unsup;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic       v;
    logic       u;
    logic [2:0] c;
    bit         use_c;
    string      req;
  } exp_t;

  exp_t sb[$];
  event chk_ev;

  always #2 clk = ~clk;

  mclk_ratio_detect uut (
    .mclk_i       (clk),
    .arst_ni      (arst_n),
    .wclk_i       (wclk),
    .slave_mode_i (slave),
    .reg_ratio_i  (reg_ratio),
    .ratio_o      (ratio),
    .valid_o      (valid),
    .unsup_o      (unsup)
  );

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (valid !== e.v || unsup !== e.u || (e.use_c && ratio !== e.c)) begin
          fails++;
          $display("FAIL %s: valid/unsup/ratio = %b/%b/%0d, expected %b/%b/%0d",
                   e.req, valid, unsup, ratio, e.v, e.u, e.c);
        end
        checks++;
        if (valid === 1'b1 && unsup === 1'b1) begin
          fails++;
          $display("FAIL R8 (%s): valid=%b unsup=%b, expected not both 1",
                   e.req, valid, unsup);
        end
      end
    end
  end

  task automatic expect_out(input logic v, input logic u, input logic [2:0] c,
                            input bit use_c, input string req);
    exp_t e;
    e.v = v; e.u = u; e.c = c; e.use_c = use_c; e.req = req;
    sb.push_back(e);
    ->chk_ev;
    @(negedge clk);
  endtask

  // Drives n word-clock periods of p master clock cycles, starting with a rise.
  task automatic run_wclk(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      wclk = 1'b1;
      repeat (p / 2) @(negedge clk);
      wclk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run not finished, expected completion");
    finish_run();
  end

  initial begin
    arst_n    = 1'b0;
    wclk      = 1'b0;
    slave     = 1'b1;
    reg_ratio = 3'd0;
    repeat (4) @(negedge clk);
    expect_out(1'b0, 1'b0, 3'd0, 1, "R1 reset state");
    arst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_wclk(256, 2);
    expect_out(1'b0, 1'b0, 3'd0, 0, "R4 one measurement after reset");
    run_wclk(256, 1);
    expect_out(1'b1, 1'b0, 3'd2, 1, "R2 ratio 256 -> code 2");

    run_wclk(384, 2);
    expect_out(1'b0, 1'b0, 3'd0, 0, "R4 new ratio seen once");
    run_wclk(384, 1);
    expect_out(1'b1, 1'b0, 3'd3, 1, "R2 ratio 384 -> code 3");

    run_wclk(130, 3);
    expect_out(1'b1, 1'b0, 3'd0, 1, "R3 period 130 -> code 0");
    run_wclk(1150, 3);
    expect_out(1'b1, 1'b0, 3'd6, 1, "R3 period 1150 -> code 6");

    run_wclk(131, 2);
    expect_out(1'b0, 1'b1, 3'd0, 0, "R5 R3 period 131 unsupported");
    run_wclk(192, 3);
    expect_out(1'b1, 1'b0, 3'd1, 1, "R5 unsup cleared, 192 -> code 1");

    run_wclk(768, 3);
    expect_out(1'b1, 1'b0, 3'd5, 1, "R2 ratio 768 -> code 5");
    run_wclk(512, 3);
    expect_out(1'b1, 1'b0, 3'd4, 1, "R2 ratio 512 -> code 4");
    run_wclk(128, 3);
    expect_out(1'b1, 1'b0, 3'd0, 1, "R2 ratio 128 -> code 0");

    wclk = 1'b0;
    repeat (1000) @(negedge clk);
    expect_out(1'b1, 1'b0, 3'd0, 1, "R6 no timeout before saturation");
    repeat (1200) @(negedge clk);
    expect_out(1'b0, 1'b1, 3'd0, 0, "R6 stopped word clock unsupported");
    run_wclk(256, 2);
    expect_out(1'b0, 1'b0, 3'd0, 0, "R6 restart first period 2047 rejected");
    run_wclk(256, 1);
    expect_out(1'b1, 1'b0, 3'd2, 1, "R6 recovery to code 2");
    run_wclk(1152, 3);
    expect_out(1'b1, 1'b0, 3'd6, 1, "R2 ratio 1152 -> code 6");

    slave     = 1'b0;
    reg_ratio = 3'd5;
    #1;
    expect_out(1'b1, 1'b0, 3'd5, 1, "R7 master mode code 5");
    reg_ratio = 3'd7;
    #1;
    expect_out(1'b0, 1'b1, 3'd7, 1, "R7 master mode code 7");
    slave = 1'b1;
    #1;
    expect_out(1'b1, 1'b0, 3'd6, 1, "R7 back to slave result");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule